// File: doc/BRIEF.md
# Processor Status Word Flag Unit

This unit keeps the 8-bit status word of an 8-bit accumulator machine. The ALU reports its carry, half-carry and overflow with a single strobe, and the unit latches them. Parity is not stored from software: it is taken again from the accumulator at every clock edge. Software can also load the word directly through a write port. Two bits of the word pick one of four register banks. The unit turns a 3-bit register index into a 5-bit register-file address inside the selected bank.

The ALU itself lies outside this unit. The caller works out the flag indications for each operation. For add and subtract-with-borrow they come from the usual carry and sign rules. For multiply, overflow means the product is above 255. For divide, overflow means the divisor is zero. Multiply and divide both report carry and half-carry as 0.

Top module: `psw_unit`

## Requirements
- R1: While rst_ni is low, psw_o reads 8'h00 and rf_addr_o equals reg_idx_i (bank 0).
- R2: A clock edge with upd_i high loads cy_i into bit 7, ac_i into bit 6 and ov_i into bit 2 of psw_o. Each bit is set or cleared to match its input.
- R3: A clock edge with neither upd_i nor wr_en_i high leaves bits 7..1 of psw_o unchanged.
- R4: Bit 0 of psw_o is the XOR of all acc_i bits sampled at the previous rising edge (1 for an odd count of ones). wr_data_i[0] has no effect on it.
- R5: A clock edge with wr_en_i high and upd_i low loads wr_data_i[7:1] into psw_o[7:1]. The bit positions are: carry 7, half-carry 6, user flag A 5, bank high 4, bank low 3, overflow 2, user flag B 1.
- R6: When wr_en_i and upd_i are both high on the same edge, bits 7, 6 and 2 take cy_i, ac_i and ov_i. Bits 5, 4, 3 and 1 take wr_data_i.
- R7: An edge with upd_i high and wr_en_i low leaves bits 5, 4, 3 and 1 of psw_o unchanged.
- R8: rf_addr_o equals psw_o[4:3]*8 + reg_idx_i, combinationally from reg_idx_i. Bank 0 covers 00h-07h and bank 3 covers 18h-1Fh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 8 | Current accumulator value |
| upd_i | input | 1 | Strobe that loads the ALU flag indications |
| cy_i | input | 1 | Carry or borrow indication |
| ac_i | input | 1 | Half-carry or half-borrow indication |
| ov_i | input | 1 | Overflow indication |
| wr_en_i | input | 1 | Direct write of the status word |
| wr_data_i | input | 8 | Data for the direct write |
| reg_idx_i | input | 3 | Register index inside the current bank |
| psw_o | output | 8 | Status word |
| rf_addr_o | output | 5 | Register-file address of the indexed register |

## Verification
The hardest case to reach is a flag update and a direct write landing on the same edge with values that disagree bit by bit. Only that case shows which source owns each bit. The stimulus forces this collision with complementary patterns (write all ones while the ALU reports all zeros, and the reverse). It also hits the collision often in the random mix, where each cycle draws update and write on their own. The random phase feeds the flag inputs from reference add, subtract-with-borrow, multiply and divide results. Its operands include zero divisors and carry-in chains.

// File: rtl/psw_unit_pkg.sv
package psw_unit_pkg;

  typedef struct packed {
    logic       cy;
    logic       ac;
    logic       f0;
    logic [1:0] bank;
    logic       ov;
    logic       f1;
    logic       p;
  } psw_t;

  localparam int unsigned PSW_W  = $bits(psw_t);
  localparam int unsigned BANK_W = 2;

endpackage

// File: rtl/psw_parity_gen.sv
module psw_parity_gen #(
  parameter int unsigned ACC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] acc_i,
  output logic             par_o
);
  logic [ACC_W-1:0] chain;

  // ripple XOR chain
  generate
    for (genvar i = 0; i < ACC_W; i++) begin : g_chain
      if (i == 0) begin : g_first
        assign chain[i] = acc_i[i];
      end else begin : g_next
        assign chain[i] = chain[i-1] ^ acc_i[i];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) par_o <= 1'b0;
    else         par_o <= chain[ACC_W-1];
  end
endmodule

// File: rtl/psw_flag_regs.sv
module psw_flag_regs
  import psw_unit_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  upd_i,
  input  logic  cy_i,
  input  logic  ac_i,
  input  logic  ov_i,
  input  logic  wr_en_i,
  input  psw_t  wr_word_i,
  output psw_t  flags_o
);
  // arithmetic-owned bits: ALU update has priority over a write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o.cy <= 1'b0;
      flags_o.ac <= 1'b0;
      flags_o.ov <= 1'b0;
    end else if (upd_i) begin
      flags_o.cy <= cy_i;
      flags_o.ac <= ac_i;
      flags_o.ov <= ov_i;
    end else if (wr_en_i) begin
      flags_o.cy <= wr_word_i.cy;
      flags_o.ac <= wr_word_i.ac;
      flags_o.ov <= wr_word_i.ov;
    end
  end

  // software-owned bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o.f0   <= 1'b0;
      flags_o.bank <= '0;
      flags_o.f1   <= 1'b0;
    end else if (wr_en_i) begin
      flags_o.f0   <= wr_word_i.f0;
      flags_o.bank <= wr_word_i.bank;
      flags_o.f1   <= wr_word_i.f1;
    end
  end

  // parity slot is filled by the parity generator at the top
  assign flags_o.p = 1'b0;
endmodule

// File: rtl/psw_bank_map.sv
module psw_bank_map #(
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned BANK_REGS = 8,
  localparam int unsigned IDX_W    = $clog2(BANK_REGS),
  localparam int unsigned ADDR_W   = BANK_W + IDX_W
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  assign addr_o = ADDR_W'(bank_i) * ADDR_W'(BANK_REGS) + ADDR_W'(idx_i);
endmodule

// File: rtl/psw_unit.sv
module psw_unit
  import psw_unit_pkg::*;
#(
  parameter int unsigned ACC_W     = 8,
  parameter int unsigned BANK_REGS = 8,
  localparam int unsigned IDX_W    = $clog2(BANK_REGS),
  localparam int unsigned ADDR_W   = BANK_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic              upd_i,
  input  logic              cy_i,
  input  logic              ac_i,
  input  logic              ov_i,
  input  logic              wr_en_i,
  input  logic [PSW_W-1:0]  wr_data_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  output logic [PSW_W-1:0]  psw_o,
  output logic [ADDR_W-1:0] rf_addr_o
);
  psw_t flags;
  psw_t wr_word;
  logic par;

  assign wr_word = psw_t'(wr_data_i);

  psw_parity_gen #(.ACC_W(ACC_W)) u_parity (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (acc_i),
    .par_o  (par)
  );

  psw_flag_regs u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (upd_i),
    .cy_i      (cy_i),
    .ac_i      (ac_i),
    .ov_i      (ov_i),
    .wr_en_i   (wr_en_i),
    .wr_word_i (wr_word),
    .flags_o   (flags)
  );

  psw_bank_map #(.BANK_W(BANK_W), .BANK_REGS(BANK_REGS)) u_bank (
    .bank_i (flags.bank),
    .idx_i  (reg_idx_i),
    .addr_o (rf_addr_o)
  );

  assign psw_o = {flags.cy, flags.ac, flags.f0, flags.bank, flags.ov, flags.f1, par};
endmodule

// File: rtl/psw_unit_chk.sv
module psw_unit_chk #(
  parameter int unsigned ACC_W  = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ACC_W-1:0]  acc_i,
  input logic              upd_i,
  input logic              cy_i,
  input logic              ac_i,
  input logic              ov_i,
  input logic              wr_en_i,
  input logic [7:0]        wr_data_i,
  input logic [IDX_W-1:0]  reg_idx_i,
  input logic [7:0]        psw_o,
  input logic [ADDR_W-1:0] rf_addr_o
);
  p_reset_zero_r1: assert property (@(posedge clk_i) !rst_ni |-> psw_o == 8'h00);

  p_arith_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> {psw_o[7], psw_o[6], psw_o[2]} == $past({cy_i, ac_i, ov_i}));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !wr_en_i) |=> $stable(psw_o[7:1]));

  p_parity_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> psw_o[0] == ^$past(acc_i));

  p_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !upd_i) |=> psw_o[7:1] == $past(wr_data_i[7:1]));

  p_collide_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && upd_i) |=> {psw_o[5:3], psw_o[1]} == $past({wr_data_i[5:3], wr_data_i[1]}));

  p_user_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_en_i) |=> $stable({psw_o[5:3], psw_o[1]}));

  p_bank_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rf_addr_o) == int'(psw_o[4:3]) * 8 + int'(reg_idx_i));
endmodule

bind psw_unit psw_unit_chk #(.ACC_W(ACC_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .acc_i     (acc_i),
  .upd_i     (upd_i),
  .cy_i      (cy_i),
  .ac_i      (ac_i),
  .ov_i      (ov_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .reg_idx_i (reg_idx_i),
  .psw_o     (psw_o),
  .rf_addr_o (rf_addr_o)
);

// File: tb/psw_unit_bench.sv
module psw_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] acc_i = '0;
  logic       upd_i = 1'b0, cy_i = 1'b0, ac_i = 1'b0, ov_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [2:0] reg_idx_i = '0;
  logic [7:0] psw_o;
  logic [4:0] rf_addr_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_psw = 8'h00;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  psw_unit u_psw_unit (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // reference flags {cy,ac,ov} and result
  function automatic logic [10:0] ref_add(input logic [7:0] a, b, input logic cin);
    logic [8:0] s = {1'b0, a} + {1'b0, b} + 9'(cin);
    logic h = (5'(a[3:0]) + 5'(b[3:0]) + 5'(cin)) > 5'd15;
    logic o = (a[7] == b[7]) && (s[7] != a[7]);
    return {s[8], h, o, s[7:0]};
  endfunction
  function automatic logic [10:0] ref_subb(input logic [7:0] a, b, input logic cin);
    logic [8:0] d = {1'b0, a} - {1'b0, b} - 9'(cin);
    logic h = 5'(a[3:0]) < (5'(b[3:0]) + 5'(cin));
    logic o = (a[7] != b[7]) && (d[7] != a[7]);
    return {d[8], h, o, d[7:0]};
  endfunction
  function automatic logic [10:0] ref_mul(input logic [7:0] a, b);
    logic [15:0] p = 16'(a) * 16'(b);
    return {1'b0, 1'b0, p > 16'd255, p[7:0]};
  endfunction
  function automatic logic [10:0] ref_div(input logic [7:0] a, b);
    return {1'b0, 1'b0, b == 8'd0, (b == 8'd0) ? 8'd0 : a / b};
  endfunction

  // one cycle; model next word from requirements, then check after the edge
  task automatic step(input logic [7:0] acc, input logic upd, input logic [2:0] fl,
                      input logic wr, input logic [7:0] wd, input logic [2:0] idx,
                      input string tag);
    @(negedge clk_i);
    acc_i = acc; upd_i = upd; {cy_i, ac_i, ov_i} = fl;
    wr_en_i = wr; wr_data_i = wd; reg_idx_i = idx;
    if (wr) begin
      exp_psw[5:3] = wd[5:3]; exp_psw[1] = wd[1];
      if (!upd) begin exp_psw[7:6] = wd[7:6]; exp_psw[2] = wd[2]; end
    end
    if (upd) begin exp_psw[7:6] = fl[2:1]; exp_psw[2] = fl[0]; end
    exp_psw[0] = ^acc;
    @(posedge clk_i); #1;
    check(tag, psw_o, exp_psw);
    check("R8 bank address", {3'b0, rf_addr_o}, 8'(int'(exp_psw[4:3]) * 8 + int'(idx)));
  endtask

  initial begin
    process::self().srandom(32'h5eed_1234);
    #(CLK_PERIOD*2 + 2);
    reg_idx_i = 3'd5; #1;
    check("R1 reset word", psw_o, 8'h00);
    check("R1 reset address", {3'b0, rf_addr_o}, 8'd5);
    @(negedge clk_i); rst_ni = 1'b1;

    step(8'h00, 1'b0, 3'b000, 1'b1, 8'hFF, 3'd7, "R5 write all ones, R4 P write ignored");
    step(8'h00, 1'b0, 3'b111, 1'b0, 8'h00, 3'd0, "R3 hold with idle strobes");
    step(8'h01, 1'b1, 3'b000, 1'b0, 8'h00, 3'd2, "R2 clear arith flags, R7 user bits kept");
    step(8'h03, 1'b1, 3'b101, 1'b0, 8'h00, 3'd1, "R2 set cy ov, R4 even parity");
    step(8'h80, 1'b1, 3'b000, 1'b1, 8'hFF, 3'd4, "R6 collide: ALU zeros vs write ones");
    step(8'hFE, 1'b1, 3'b111, 1'b1, 8'h00, 3'd3, "R6 collide: ALU ones vs write zeros");
    for (int b = 0; b < 4; b++)
      step(8'h00, 1'b0, 3'b000, 1'b1, 8'(b << 3), 3'(b + 3), "R8 bank walk, R5 bank field");

    for (int i = 0; i < 400; i++) begin
      logic [7:0] a = 8'($urandom), b = 8'($urandom);
      logic [10:0] r;
      logic cin = exp_psw[7];
      int op = $urandom_range(0, 3);
      if ($urandom_range(0, 7) == 0) b = 8'h00;
      case (op)
        0: r = ref_add(a, b, cin);
        1: r = ref_subb(a, b, cin);
        2: r = ref_mul(a, b);
        default: r = ref_div(a, b);
      endcase
      step(r[7:0], 1'($urandom_range(0, 1)), r[10:8], ($urandom_range(0, 3) == 0),
           8'($urandom), 3'($urandom), "R2 R4 R5 R6 R7 random op");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule